// File: doc/BRIEF.md
# Crate Dataway Command Decoder

This block sits between a crate controller and an eight-channel conversion front end. Each cycle with the strobe high, it takes a 5-bit function code, a 4-bit subaddress and a write word. It either reads or writes a small configuration store, or acts on the block's control state. The store holds upper and lower threshold banks, per-channel offsets, a shared threshold and a 16-bit status word. The control state is the look-at-me (LAM) flag and a data-ready flag.

Every mapped command returns X and a Q that depends on the command. The initialize (Z) and clear (C) levels both wipe the module's conversion state, but only initialize also resets the status word. The inhibit level is passed on, registered, as a gate-block signal. An end-of-conversion pulse marks data as ready. It raises the LAM only when the status word enables the LAM and routes readout to the dataway rather than the front panel.

Top module: `crate_cmd_decoder`

## Requirements
- R1: After reset, rdata_o, q_o, x_o, lam_o, clr_o and inh_o are 0, and the status word reads as 0.
- R2: Function 17 writes and function 1 reads one threshold memory. Subaddresses 0..7 hold the eight upper thresholds and 8..15 hold the eight lower thresholds. All sixteen entries are independent and read back zero-extended to 16 bits.
- R3: Function 20 writes and function 4 reads three targets: per-channel offsets at subaddresses 0..7, the shared threshold at subaddress 9 and the 16-bit status word at subaddress 14. Status bit 0 enables the LAM, bit 1 selects front-panel readout and bit 2 selects addressed readout.
- R4: x_o, q_o and rdata_o are registered one cycle after a strobed command. They are 0 in any cycle that follows a cycle without strobe. rdata_o is 0 for commands that return no data.
- R5: A strobed function/subaddress pair outside the map gives x_o=0, q_o=0 and rdata_o=0, and alters no stored value and no flag. Every mapped pair gives x_o=1, and q_o=1 except as stated in R6 and R12.
- R6: An end-of-conversion pulse sets the LAM only when status bit 0 is 1 and bit 1 is 0. Function 8 at subaddress 0 returns q_o equal to the LAM.
- R7: Function 0 at subaddress 15 returns the 8-bit pattern input, zero-extended, and leaves the LAM alone. Function 2 at subaddress 15 returns the same word and clears the LAM. Function 10 at subaddress 0 clears the LAM.
- R8: A clear (C) level clears the LAM and data-ready and gives a clr_o pulse the next cycle. It keeps the status word and all threshold and offset values.
- R9: An initialize (Z) level does everything C does and also zeroes the status word. Threshold and offset values are kept.
- R10: Function 9 at subaddress 0 clears the module as C does, with clr_o high one cycle later.
- R11: inh_o equals the inhibit input delayed by one clock.
- R12: With status bit 2 set, functions 0 and 2 at subaddresses 0..7 return that channel's 16-bit word, with q_o equal to data-ready. Function 2 at subaddress 7 then also clears the module. With bit 2 clear, these pairs are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_i | input | 5 | Function code |
| sa_i | input | 4 | Subaddress |
| wdata_i | input | 16 | Write data |
| strobe_i | input | 1 | Command valid, one cycle per command |
| z_i | input | 1 | Initialize level |
| c_i | input | 1 | Clear level |
| i_i | input | 1 | Inhibit level |
| eoc_i | input | 1 | End-of-conversion pulse |
| pattern_i | input | 8 | Hit pattern word source |
| chdata_i | input | 128 | Eight converted 16-bit channel words, channel 0 in the low bits |
| rdata_o | output | 16 | Registered read data |
| q_o | output | 1 | Registered Q response |
| x_o | output | 1 | Registered X response |
| lam_o | output | 1 | Look-at-me flag |
| clr_o | output | 1 | Module-clear pulse |
| inh_o | output | 1 | Gate inhibit |

## Verification
The responses X, Q and read data, along with clr_o, all appear on the clock edge that ends the strobed cycle. The bench drives each command from one falling edge and samples at the next, so exactly one rising edge lies between them. The LAM and data-ready flags change on the edge that ends an end-of-conversion or clear cycle, so the bench observes them at the falling edge right after that cycle. The inhibit output is checked one edge after each change of its input. Writes are checked only through later reads. This confirms both the store and the one-cycle latency together.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

  localparam int FN_W = 5;
  localparam int SA_W = 4;

  // status word bit positions
  localparam int STS_LAM_EN  = 0;
  localparam int STS_FP_RD   = 1;
  localparam int STS_ADDR_RD = 2;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_THR,
    OP_WR_THR,
    OP_RD_OFS,
    OP_WR_OFS,
    OP_RD_COM,
    OP_WR_COM,
    OP_RD_STS,
    OP_WR_STS,
    OP_TEST_LAM,
    OP_CLR_MOD,
    OP_CLR_LAM,
    OP_RD_PAT,
    OP_RD_CHAN
  } op_e;

  typedef struct packed {
    logic valid;
    op_e  op;
    logic clr_lam;
    logic clr_mod;
  } dec_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdec_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int SA_COM = 9,
  parameter int SA_STS = 14,
  parameter int SA_PAT = 15
) (
  input  logic [FN_W-1:0] fn,
  input  logic [SA_W-1:0] sa,
  input  logic            addr_mode,
  output dec_t            dec
);

  localparam int THR_N = 2 * NCH;

  always_comb begin
    dec = '{valid: 1'b0, op: OP_NONE, clr_lam: 1'b0, clr_mod: 1'b0};
    case (fn)
      5'd0, 5'd2: begin
        if (int'(sa) == SA_PAT) begin
          dec.valid   = 1'b1;
          dec.op      = OP_RD_PAT;
          dec.clr_lam = (fn == 5'd2);
        end else if (int'(sa) < NCH && addr_mode) begin
          dec.valid   = 1'b1;
          dec.op      = OP_RD_CHAN;
          dec.clr_mod = (fn == 5'd2) && (int'(sa) == NCH - 1);
        end
      end
      5'd1: begin
        if (int'(sa) < THR_N) begin
          dec.valid = 1'b1;
          dec.op    = OP_RD_THR;
        end
      end
      5'd17: begin
        if (int'(sa) < THR_N) begin
          dec.valid = 1'b1;
          dec.op    = OP_WR_THR;
        end
      end
      5'd4: begin
        if (int'(sa) < NCH) begin
          dec.valid = 1'b1;
          dec.op    = OP_RD_OFS;
        end else if (int'(sa) == SA_COM) begin
          dec.valid = 1'b1;
          dec.op    = OP_RD_COM;
        end else if (int'(sa) == SA_STS) begin
          dec.valid = 1'b1;
          dec.op    = OP_RD_STS;
        end
      end
      5'd20: begin
        if (int'(sa) < NCH) begin
          dec.valid = 1'b1;
          dec.op    = OP_WR_OFS;
        end else if (int'(sa) == SA_COM) begin
          dec.valid = 1'b1;
          dec.op    = OP_WR_COM;
        end else if (int'(sa) == SA_STS) begin
          dec.valid = 1'b1;
          dec.op    = OP_WR_STS;
        end
      end
      5'd8: begin
        if (sa == '0) begin
          dec.valid = 1'b1;
          dec.op    = OP_TEST_LAM;
        end
      end
      5'd9: begin
        if (sa == '0) begin
          dec.valid   = 1'b1;
          dec.op      = OP_CLR_MOD;
          dec.clr_mod = 1'b1;
        end
      end
      5'd10: begin
        if (sa == '0) begin
          dec.valid   = 1'b1;
          dec.op      = OP_CLR_LAM;
          dec.clr_lam = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cmdec_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 8,
  parameter int OW  = 8,
  parameter int SW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            z_clr,
  input  logic            we_thr,
  input  logic            we_ofs,
  input  logic            we_com,
  input  logic            we_sts,
  input  logic [SA_W-1:0] sa,
  input  logic [TW-1:0]   wd_thr,
  input  logic [OW-1:0]   wd_ofs,
  input  logic [SW-1:0]   wd_sts,
  output logic [TW-1:0]   thr_rd,
  output logic [OW-1:0]   ofs_rd,
  output logic [TW-1:0]   com_rd,
  output logic [SW-1:0]   sts
);

  localparam int THR_N = 2 * NCH;
  localparam int IW    = $clog2(NCH);

  logic [TW-1:0] thr_mem [THR_N];
  logic [OW-1:0] ofs_mem [NCH];
  logic [TW-1:0] com_q;

  // memories: no reset, single write port, asynchronous read
  always_ff @(posedge clk) begin
    if (we_thr) thr_mem[sa] <= wd_thr;
  end

  always_ff @(posedge clk) begin
    if (we_ofs) ofs_mem[sa[IW-1:0]] <= wd_ofs;
  end

  assign thr_rd = thr_mem[sa];
  assign ofs_rd = ofs_mem[sa[IW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      com_q <= '0;
      sts   <= '0;
    end else begin
      if (we_com) com_q <= wd_thr;
      if (z_clr)       sts <= '0;
      else if (we_sts) sts <= wd_sts;
    end
  end

  assign com_rd = com_q;

  AST_Z_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
    z_clr |=> (sts == '0)); // R9

  AST_STS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!z_clr && !we_sts) |=> $stable(sts)); // R5

endmodule

// File: rtl/lam_ctrl.sv
module lam_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic eoc,
  input  logic lam_en,
  input  logic fp_rd,
  input  logic clr_lam,
  input  logic mod_clr,
  output logic lam,
  output logic dready
);

  logic lam_set;
  assign lam_set = eoc && lam_en && !fp_rd;

  always_ff @(posedge clk) begin
    if (rst || mod_clr || clr_lam) lam <= 1'b0;
    else if (lam_set)              lam <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || mod_clr) dready <= 1'b0;
    else if (eoc)       dready <= 1'b1;
  end

  AST_LAM_RAISE: assert property (@(posedge clk) disable iff (rst)
    (eoc && lam_en && !fp_rd && !clr_lam && !mod_clr) |=> lam); // R6

  AST_LAM_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!lam && !(eoc && lam_en && !fp_rd)) |=> !lam); // R6

  AST_CLR_WIPES_FLAGS: assert property (@(posedge clk) disable iff (rst)
    mod_clr |=> (!lam && !dready)); // R8

  AST_LAM_CMD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_lam |=> !lam); // R7

endmodule

// File: rtl/crate_cmd_decoder.sv
module crate_cmd_decoder
  import cmdec_pkg::*;
#(
  parameter int NCH = 8,
  parameter int TW  = 8,
  parameter int OW  = 8,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        fn_i,
  input  logic [3:0]        sa_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              strobe_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic              i_i,
  input  logic              eoc_i,
  input  logic [NCH-1:0]    pattern_i,
  input  logic [NCH*DW-1:0] chdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              q_o,
  output logic              x_o,
  output logic              lam_o,
  output logic              clr_o,
  output logic              inh_o
);

  localparam int IW = $clog2(NCH);

  dec_t          dec;
  logic          go;
  logic          mod_clr;
  logic          lam_clr;
  logic [TW-1:0] thr_rd;
  logic [OW-1:0] ofs_rd;
  logic [TW-1:0] com_rd;
  logic [DW-1:0] sts;
  logic          lam;
  logic          dready;
  logic [DW-1:0] rd_val;
  logic          q_val;
  logic [DW-1:0] chan_w [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan_w[g] = chdata_i[g*DW +: DW];
  end

  cmd_decode #(.NCH(NCH)) u_dec (
    .fn        (fn_i),
    .sa        (sa_i),
    .addr_mode (sts[STS_ADDR_RD]),
    .dec       (dec)
  );

  assign go      = strobe_i && dec.valid;
  assign mod_clr = z_i || c_i || (go && dec.clr_mod);
  assign lam_clr = go && dec.clr_lam;

  cfg_regfile #(.NCH(NCH), .TW(TW), .OW(OW), .SW(DW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .z_clr  (z_i),
    .we_thr (go && dec.op == OP_WR_THR),
    .we_ofs (go && dec.op == OP_WR_OFS),
    .we_com (go && dec.op == OP_WR_COM),
    .we_sts (go && dec.op == OP_WR_STS),
    .sa     (sa_i),
    .wd_thr (wdata_i[TW-1:0]),
    .wd_ofs (wdata_i[OW-1:0]),
    .wd_sts (wdata_i),
    .thr_rd (thr_rd),
    .ofs_rd (ofs_rd),
    .com_rd (com_rd),
    .sts    (sts)
  );

  lam_ctrl u_lam (
    .clk     (clk),
    .rst     (rst),
    .eoc     (eoc_i),
    .lam_en  (sts[STS_LAM_EN]),
    .fp_rd   (sts[STS_FP_RD]),
    .clr_lam (lam_clr),
    .mod_clr (mod_clr),
    .lam     (lam),
    .dready  (dready)
  );

  always_comb begin
    rd_val = '0;
    q_val  = 1'b1;
    case (dec.op)
      OP_RD_THR:   rd_val = {{(DW-TW){1'b0}}, thr_rd};
      OP_RD_OFS:   rd_val = {{(DW-OW){1'b0}}, ofs_rd};
      OP_RD_COM:   rd_val = {{(DW-TW){1'b0}}, com_rd};
      OP_RD_STS:   rd_val = sts;
      OP_RD_PAT:   rd_val = {{(DW-NCH){1'b0}}, pattern_i};
      OP_RD_CHAN: begin
        rd_val = chan_w[sa_i[IW-1:0]];
        q_val  = dready;
      end
      OP_TEST_LAM: q_val = lam;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      q_o     <= 1'b0;
      x_o     <= 1'b0;
      clr_o   <= 1'b0;
      inh_o   <= 1'b0;
    end else begin
      x_o     <= go;
      q_o     <= go && q_val;
      rdata_o <= go ? rd_val : '0;
      clr_o   <= mod_clr;
      inh_o   <= i_i;
    end
  end

  assign lam_o = lam;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> (!x_o && !q_o && rdata_o == '0)); // R4

  AST_Q_NEEDS_X: assert property (@(posedge clk) disable iff (rst)
    q_o |-> x_o); // R5

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (c_i || z_i) |=> clr_o); // R8

  AST_INH_RISE: assert property (@(posedge clk) disable iff (rst)
    i_i |=> inh_o); // R11

  AST_INH_FALL: assert property (@(posedge clk) disable iff (rst)
    !i_i |=> !inh_o); // R11

  AST_LAM_TEST_Q: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && fn_i == 5'd8 && sa_i == 4'd0) |=> (x_o && q_o == $past(lam_o))); // R6

endmodule

// File: tb/crate_cmd_decoder_bench.sv
module crate_cmd_decoder_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   fn = '0;
  logic [3:0]   sa = '0;
  logic [15:0]  wd = '0;
  logic         stb = 1'b0, z = 1'b0, c = 1'b0, ii = 1'b0, eoc = 1'b0;
  logic [7:0]   pat = 8'hA5;
  logic [127:0] chd;
  logic [15:0]  rdata_o;
  logic         q_o, x_o, lam_o, clr_o, inh_o;

  int tests = 0, fails = 0;
  logic        cx, cq, cc;
  logic [15:0] cd;

  always #5 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_chd
    assign chd[g*16 +: 16] = 16'h1000 + 16'(g * 16'h0111);
  end

  crate_cmd_decoder u_crate_cmd_decoder (
    .clk(clk), .rst(rst), .fn_i(fn), .sa_i(sa), .wdata_i(wd), .strobe_i(stb),
    .z_i(z), .c_i(c), .i_i(ii), .eoc_i(eoc), .pattern_i(pat), .chdata_i(chd),
    .rdata_o(rdata_o), .q_o(q_o), .x_o(x_o), .lam_o(lam_o), .clr_o(clr_o), .inh_o(inh_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] f, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    fn = f; sa = a; wd = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    cx = x_o; cq = q_o; cd = rdata_o; cc = clr_o;
  endtask

  task automatic pulse_eoc();
    @(negedge clk); eoc = 1'b1;
    @(negedge clk); eoc = 1'b0;
  endtask

  function automatic logic mapped(input int f, input int a, input logic amode);
    case (f)
      0, 2:    return (a == 15) || (a < 8 && amode);
      1, 17:   return 1'b1;
      4, 20:   return (a < 8) || (a == 9) || (a == 14);
      8, 9, 10: return (a == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] thr_val(input int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata_o, 0); chk("R1 q", q_o, 0); chk("R1 x", x_o, 0);
    chk("R1 lam", lam_o, 0); chk("R1 clr", clr_o, 0); chk("R1 inh", inh_o, 0);
    cmd(5'd4, 4'd14, 0); chk("R1 status", cd, 0);

    // R2 threshold banks
    for (int a = 0; a < 16; a++) cmd(5'd17, 4'(a), {8'hEE, thr_val(a)});
    for (int a = 0; a < 16; a++) begin
      cmd(5'd1, 4'(a), 0);
      chk("R2 thr read", cd, {8'h00, thr_val(a)});
      chk("R2 x", cx, 1); chk("R2 q", cq, 1);
    end
    // R4 idle cycle silent
    @(negedge clk);
    chk("R4 idle x", x_o, 0); chk("R4 idle q", q_o, 0); chk("R4 idle rdata", rdata_o, 0);

    // R3 offsets, shared threshold, status
    for (int a = 0; a < 8; a++) cmd(5'd20, 4'(a), 16'(a * 11 + 3));
    cmd(5'd20, 4'd9, 16'h005A);
    cmd(5'd20, 4'd14, 16'h00F0);
    for (int a = 0; a < 8; a++) begin
      cmd(5'd4, 4'(a), 0); chk("R3 offset", cd, 16'(a * 11 + 3));
    end
    cmd(5'd4, 4'd9, 0);  chk("R3 shared", cd, 16'h005A);
    cmd(5'd4, 4'd14, 0); chk("R3 status", cd, 16'h00F0);

    // R5 exhaustive unmapped sweep
    for (int f = 0; f < 32; f++) begin
      for (int a = 0; a < 16; a++) begin
        if (!mapped(f, a, 1'b0)) begin
          cmd(5'(f), 4'(a), 16'hFFFF);
          chk("R5 unmapped x", cx, 0); chk("R5 unmapped q", cq, 0);
          chk("R5 unmapped rdata", cd, 0);
        end
      end
    end
    for (int a = 0; a < 16; a++) begin
      cmd(5'd1, 4'(a), 0); chk("R5 thr kept", cd, {8'h00, thr_val(a)});
    end
    cmd(5'd4, 4'd14, 0); chk("R5 status kept", cd, 16'h00F0);
    chk("R5 lam kept", lam_o, 0);

    // R6 LAM qualification
    cmd(5'd20, 4'd14, 16'h0000); pulse_eoc(); chk("R6 lam disabled", lam_o, 0);
    cmd(5'd20, 4'd14, 16'h0003); pulse_eoc(); chk("R6 lam front panel", lam_o, 0);
    cmd(5'd8, 4'd0, 0); chk("R6 test x", cx, 1); chk("R6 test q low", cq, 0);
    cmd(5'd20, 4'd14, 16'h0001); pulse_eoc(); chk("R6 lam set", lam_o, 1);
    cmd(5'd8, 4'd0, 0); chk("R6 test q high", cq, 1);

    // R7 pattern reads and LAM clears
    cmd(5'd0, 4'd15, 0); chk("R7 pattern", cd, 16'h00A5); chk("R7 F0 keeps lam", lam_o, 1);
    cmd(5'd2, 4'd15, 0); chk("R7 pattern F2", cd, 16'h00A5); chk("R7 F2 clears lam", lam_o, 0);
    pulse_eoc(); chk("R7 lam again", lam_o, 1);
    cmd(5'd10, 4'd0, 0); chk("R7 F10 x", cx, 1); chk("R7 F10 clears", lam_o, 0);

    // R8 clear level
    pulse_eoc();
    @(negedge clk); c = 1'b1;
    @(negedge clk); c = 1'b0;
    chk("R8 clr pulse", clr_o, 1); chk("R8 lam cleared", lam_o, 0);
    cmd(5'd4, 4'd14, 0); chk("R8 status kept", cd, 16'h0001);
    cmd(5'd1, 4'd12, 0); chk("R8 thr kept", cd, {8'h00, thr_val(12)});
    cmd(5'd4, 4'd5, 0);  chk("R8 offset kept", cd, 16'(5 * 11 + 3));

    // R10 clear by function 9
    pulse_eoc(); chk("R10 lam set", lam_o, 1);
    cmd(5'd9, 4'd0, 0);
    chk("R10 x", cx, 1); chk("R10 clr", cc, 1); chk("R10 lam", lam_o, 0);

    // R9 initialize level
    @(negedge clk); z = 1'b1;
    @(negedge clk); z = 1'b0;
    chk("R9 clr pulse", clr_o, 1);
    cmd(5'd4, 4'd14, 0); chk("R9 status zero", cd, 0);
    cmd(5'd1, 4'd3, 0);  chk("R9 thr kept", cd, {8'h00, thr_val(3)});
    cmd(5'd4, 4'd9, 0);  chk("R9 shared kept", cd, 16'h005A);

    // R11 inhibit
    @(negedge clk); ii = 1'b1;
    @(negedge clk); chk("R11 inh high", inh_o, 1); ii = 1'b0;
    @(negedge clk); chk("R11 inh low", inh_o, 0);

    // R12 addressed readout
    cmd(5'd0, 4'd3, 0); chk("R12 unmapped when sequential", cx, 0);
    cmd(5'd20, 4'd14, 16'h0004);
    cmd(5'd0, 4'd3, 0); chk("R12 x", cx, 1); chk("R12 q not ready", cq, 0);
    pulse_eoc();
    for (int a = 0; a < 7; a++) begin
      cmd(5'd0, 4'(a), 0);
      chk("R12 chan data", cd, 16'h1000 + 16'(a * 16'h0111)); chk("R12 q ready", cq, 1);
    end
    cmd(5'd2, 4'd7, 0);
    chk("R12 last chan", cd, 16'h1777); chk("R12 last q", cq, 1); chk("R12 clears", cc, 1);
    cmd(5'd0, 4'd3, 0); chk("R12 q after clear", cq, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule